// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller

This block turns a 26 x 5 dot display buffer into drive selections for a multiplexed liquid-crystal panel. It does not produce analog voltages. Each common and segment pin gets a 2-bit code that picks one of four rails: ground, a lower intermediate level, an upper intermediate level, or VDD. An external analog stage turns these codes into voltages. The block runs entirely from the slow 32.768 kHz clock domain, so the panel keeps refreshing while the processor is halted.

A 6-bit control word selects the following:
- how many commons are scanned (2 to 5);
- 1/2 or 1/3 bias;
- display on or blanked;
- whether the two highest segment pins are handed to general I/O;
- whether the highest common pin is handed to general I/O.

Each frame walks the active commons in ascending order. Each common holds its slot for a fixed number of clocks. The drive polarity flips after every frame so that no pixel sees a DC component.

Top module: `lcd_mux_driver`

## Requirements
- R1: While reset is asserted and right after it, the control word reads zero. All level codes are 0, every output-enable bit is 1, and `framePol` is 0. The scan count then starts at two commons, in half bias.
- R2: Common index k (k = 0, 1, ...) is the selected common for exactly SLOT_TICKS consecutive clocks, in ascending order. A frame covers commons 0 to n-1, where n = control bits [3:2] + 2, capped at NUM_COM.
- R3: Common codes depend on bias and polarity.
  - Selected common: code 3 when polarity is 0, code 0 when polarity is 1.
  - Unselected common: code 1, except in 1/3 bias (control bit 1 = 1) with polarity 1, where it is code 2.
- R4: Segment s is "on" when `dispBuf[s*NUM_COM + k]` is 1, with k the selected common.
  - 1/2 bias: polarity 0 gives on=0 / off=3; polarity 1 gives on=3 / off=0.
  - 1/3 bias: polarity 0 gives on=0 / off=2; polarity 1 gives on=3 / off=1.
- R5: `framePol` toggles on the clock edge that ends the last active common's slot. The scan then restarts at common 0.
- R6: The common count and bias are taken from the control word only on the frame-wrap edge. A write in mid-frame does not change the current frame's scan.
- R7: When control bit 0 (display on) is 0, every common and segment pin is driven with code 0. This applies from the clock after the write.
- R8: Control bit 4 releases the two highest segment pins, and bit 5 releases the highest common pin. A released pin has output enable 0 and code 0. Release takes effect from the clock after the write.
- R9: Commons at or above the active count are always driven at the unselected common level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (32.768 kHz domain) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgData | input | 6 | Control word: [0] on, [1] third bias, [3:2] commons-2, [4] segment release, [5] common release |
| dispBuf | input | 130 | Display buffer, bit s*5+k is segment s at common k |
| comLvl | output | 10 | 2-bit level code per common, common c at [2c+1:2c] |
| segLvl | output | 52 | 2-bit level code per segment, segment s at [2s+1:2s] |
| comOe | output | 5 | Per-common drive enable (0 = released to I/O) |
| segOe | output | 26 | Per-segment drive enable (0 = released to I/O) |
| framePol | output | 1 | Current frame drive polarity |

## Verification
The buffer is filled with four patterns: all ones, all zeros, alternating bits, and a sparse irregular pattern.
- All ones and all zeros show whether the on and off segment codes are swapped or merged, in both polarities.
- Alternating bits shift phase between neighbouring commons, so they catch a wrong row index or a stale common index.
- The sparse pattern catches errors in the segment stride.

Each pattern runs under both bias settings and several common counts. The duty is changed in mid-frame to show that it is only picked up at the wrap. Blanking and pin release are then toggled on a running scan.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int IDX_W = 3;   // common index width, supports up to 8 commons
  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_VDD  = 2'd3
  } lvl_e;

  // strobes and state from control to datapath
  typedef struct packed {
    logic [IDX_W-1:0] comIdx;
    logic [IDX_W-1:0] lastIdx;
    logic             pol;
    logic             biasThird;
    logic             blank;
    logic             relSeg;
    logic             relCom;
  } scan_ctl_t;

  function automatic lvl_e comLevel(input logic sel, input logic pol, input logic third);
    if (sel)                return pol ? LVL_GND : LVL_VDD;
    else if (pol && third)  return LVL_HIGH;
    else                    return LVL_LOW;
  endfunction

  function automatic lvl_e segLevel(input logic on, input logic pol, input logic third);
    if (third) begin
      if (!pol) return on ? LVL_GND : LVL_HIGH;
      else      return on ? LVL_VDD : LVL_LOW;
    end else begin
      if (!pol) return on ? LVL_GND : LVL_VDD;
      else      return on ? LVL_VDD : LVL_GND;
    end
  endfunction

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_mux_pkg::*;
#(
  parameter int NUM_COM    = 5,
  parameter int SLOT_TICKS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output scan_ctl_t        ctl
);
  localparam int SLOT_W = $clog2(SLOT_TICKS + 1);
  localparam logic [IDX_W-1:0] MAX_LAST = IDX_W'(NUM_COM - 1);

  logic [CFG_W-1:0]  ctrlReg;
  logic [SLOT_W-1:0] slotCnt;
  logic [IDX_W-1:0]  comIdx, actLast, reqRaw, reqLast;
  logic              pol, actThird;
  logic              slotEnd, frameEnd;

  assign reqRaw   = IDX_W'(ctrlReg[3:2]) + IDX_W'(1);
  assign reqLast  = (reqRaw > MAX_LAST) ? MAX_LAST : reqRaw;
  assign slotEnd  = (slotCnt == SLOT_W'(SLOT_TICKS - 1));
  assign frameEnd = slotEnd && (comIdx == actLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      slotCnt  <= '0;
      comIdx   <= '0;
      pol      <= 1'b0;
      actLast  <= IDX_W'(1);
      actThird <= 1'b0;
    end else begin
      if (cfgWe) ctrlReg <= cfgData;
      if (slotEnd) begin
        slotCnt <= '0;
        if (frameEnd) begin
          comIdx   <= '0;
          pol      <= ~pol;
          actLast  <= reqLast;
          actThird <= ctrlReg[1];
        end else begin
          comIdx <= comIdx + IDX_W'(1);
        end
      end else begin
        slotCnt <= slotCnt + SLOT_W'(1);
      end
    end
  end

  always_comb begin
    ctl.comIdx    = comIdx;
    ctl.lastIdx   = actLast;
    ctl.pol       = pol;
    ctl.biasThird = actThird;
    ctl.blank     = ~ctrlReg[0];
    ctl.relSeg    = ctrlReg[4];
    ctl.relCom    = ctrlReg[5];
  end

endmodule

// File: rtl/lcd_level_dp.sv
module lcd_level_dp
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 26,
  parameter int NUM_COM     = 5,
  parameter int NUM_REL_SEG = 2,
  parameter int NUM_REL_COM = 1
) (
  input  scan_ctl_t                    ctl,
  input  logic [NUM_SEG*NUM_COM-1:0]   dispBuf,
  output logic [2*NUM_COM-1:0]         comLvl,
  output logic [2*NUM_SEG-1:0]         segLvl,
  output logic [NUM_COM-1:0]           comOe,
  output logic [NUM_SEG-1:0]           segOe
);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    localparam bit CAN_REL = (c >= NUM_COM - NUM_REL_COM);
    logic rel;
    lvl_e lvl;
    assign rel = CAN_REL && ctl.relCom;
    always_comb begin
      if (rel || ctl.blank) lvl = LVL_GND;
      else lvl = comLevel(ctl.comIdx == IDX_W'(c), ctl.pol, ctl.biasThird);
    end
    assign comLvl[2*c +: 2] = lvl;
    assign comOe[c]         = ~rel;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam bit CAN_REL = (s >= NUM_SEG - NUM_REL_SEG);
    logic               rel;
    logic [NUM_COM-1:0] row;
    lvl_e               lvl;
    assign rel = CAN_REL && ctl.relSeg;
    assign row = dispBuf[s*NUM_COM +: NUM_COM];
    always_comb begin
      if (rel || ctl.blank) lvl = LVL_GND;
      else lvl = segLevel(row[ctl.comIdx], ctl.pol, ctl.biasThird);
    end
    assign segLvl[2*s +: 2] = lvl;
    assign segOe[s]         = ~rel;
  end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 26,
  parameter int NUM_COM     = 5,
  parameter int SLOT_TICKS  = 8,
  parameter int NUM_REL_SEG = 2,
  parameter int NUM_REL_COM = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [CFG_W-1:0]             cfgData,
  input  logic [NUM_SEG*NUM_COM-1:0]   dispBuf,
  output logic [2*NUM_COM-1:0]         comLvl,
  output logic [2*NUM_SEG-1:0]         segLvl,
  output logic [NUM_COM-1:0]           comOe,
  output logic [NUM_SEG-1:0]           segOe,
  output logic                         framePol
);

  scan_ctl_t ctl;

  lcd_scan_ctrl #(.NUM_COM(NUM_COM), .SLOT_TICKS(SLOT_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .ctl(ctl)
  );

  lcd_level_dp #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM),
    .NUM_REL_SEG(NUM_REL_SEG), .NUM_REL_COM(NUM_REL_COM)
  ) u_dp (
    .ctl(ctl), .dispBuf(dispBuf), .comLvl(comLvl), .segLvl(segLvl),
    .comOe(comOe), .segOe(segOe)
  );

  assign framePol = ctl.pol;

endmodule

// File: rtl/lcd_mux_checker.sv
module lcd_mux_checker
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 26,
  parameter int NUM_COM     = 5,
  parameter int NUM_REL_SEG = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input scan_ctl_t            ctl,
  input logic [2*NUM_COM-1:0] comLvl,
  input logic [2*NUM_SEG-1:0] segLvl,
  input logic [NUM_COM-1:0]   comOe,
  input logic [NUM_SEG-1:0]   segOe
);

  logic segMid;
  always_comb begin
    segMid = 1'b0;
    for (int s = 0; s < NUM_SEG; s++)
      if (segLvl[2*s +: 2] == LVL_LOW || segLvl[2*s +: 2] == LVL_HIGH) segMid = 1'b1;
  end

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    ctl.comIdx <= ctl.lastIdx);  // R2
  AST_POL_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctl.pol) |-> ($past(ctl.comIdx) == $past(ctl.lastIdx)) && (ctl.comIdx == '0));  // R5
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctl.lastIdx) |-> !$stable(ctl.pol));  // R6
  AST_BLANK_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blank |-> (comLvl == '0) && (segLvl == '0));  // R7
  AST_HALF_SEG_RAIL: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.biasThird |-> !segMid);  // R4
  AST_SEG_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relSeg |-> (segOe[NUM_SEG-1 -: NUM_REL_SEG] == '0));  // R8
  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.relSeg |-> (&segOe));  // R8
  AST_COM_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relCom |-> !comOe[NUM_COM-1]);  // R8
  AST_COM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.relCom |-> (&comOe));  // R8

endmodule

bind lcd_mux_driver lcd_mux_checker #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_REL_SEG(NUM_REL_SEG)
) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .comLvl(comLvl), .segLvl(segLvl),
  .comOe(comOe), .segOe(segOe)
);

// File: tb/test_lcd_mux_driver.sv
module test_lcd_mux_driver;
  localparam int NS = 26, NC = 5, SLOT = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cfgWe = 1'b0;
  logic [5:0]         cfgData = '0;
  logic [NS*NC-1:0]   dispBuf = '0;
  logic [2*NC-1:0]    comLvl;
  logic [2*NS-1:0]    segLvl;
  logic [NC-1:0]      comOe;
  logic [NS-1:0]      segOe;
  logic               framePol;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  lcd_mux_driver i_lcd_mux_driver (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .dispBuf(dispBuf),
    .comLvl(comLvl), .segLvl(segLvl), .comOe(comOe), .segOe(segOe), .framePol(framePol)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  int mSlot, mIdx, mPol, mCtrl, mLast, mThird;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSlot = 0; mIdx = 0; mPol = 0; mCtrl = 0; mLast = 1; mThird = 0;
    end else begin
      if (mSlot == SLOT - 1) begin
        mSlot = 0;
        if (mIdx == mLast) begin
          mIdx = 0; mPol = 1 - mPol;
          mLast = ((mCtrl >> 2) & 3) + 1;
          if (mLast > NC - 1) mLast = NC - 1;
          mThird = (mCtrl >> 1) & 1;
        end else mIdx++;
      end else mSlot++;
      if (cfgWe) mCtrl = cfgData;
    end
  end

  function automatic bit blankNow(); return (mCtrl & 1) == 0; endfunction
  function automatic bit comRel(int c); return c == NC - 1 && ((mCtrl >> 5) & 1); endfunction
  function automatic bit segRel(int s); return s >= NS - 2 && ((mCtrl >> 4) & 1); endfunction

  function automatic int expCom(int c);
    if (blankNow() || comRel(c)) return 0;
    if (c == mIdx) return mPol ? 0 : 3;
    return (mPol && mThird) ? 2 : 1;
  endfunction

  function automatic int expSeg(int s);
    int on;
    if (blankNow() || segRel(s)) return 0;
    on = dispBuf[s*NC + mIdx];
    if (mThird) return mPol ? (on ? 3 : 1) : (on ? 0 : 2);
    return mPol ? (on ? 3 : 0) : (on ? 0 : 3);
  endfunction

  function automatic string comTag(int c);
    if (blankNow()) return "R7";
    if (comRel(c)) return "R8";
    if (c > mLast) return "R9";
    if (c == mIdx) return "R2";
    return "R3";
  endfunction

  function automatic string segTag(int s);
    if (blankNow()) return "R7";
    if (segRel(s)) return "R8";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      begin : cmpCom
        int badC = -1;
        for (int c = 0; c < NC; c++)
          if (badC < 0 && (int'(comLvl[2*c +: 2]) != expCom(c) || comOe[c] != !comRel(c))) badC = c;
        if (badC < 0) check(1, "R3", "com", 0, 0);
        else check(0, comTag(badC), $sformatf("com%0d code/oe", badC),
                   int'(comLvl[2*badC +: 2]) * 2 + comOe[badC], expCom(badC) * 2 + !comRel(badC));
      end
      begin : cmpSeg
        int badS = -1;
        for (int s = 0; s < NS; s++)
          if (badS < 0 && (int'(segLvl[2*s +: 2]) != expSeg(s) || segOe[s] != !segRel(s))) badS = s;
        if (badS < 0) check(1, "R4", "seg", 0, 0);
        else check(0, segTag(badS), $sformatf("seg%0d code/oe", badS),
                   int'(segLvl[2*badS +: 2]) * 2 + segOe[badS], expSeg(badS) * 2 + !segRel(badS));
      end
      check(framePol == mPol[0], "R5", "framePol", framePol, mPol);
    end
  end

  task automatic writeCfg(logic [5:0] v);
    @(posedge clk); #2; cfgWe = 1'b1; cfgData = v;
    @(posedge clk); #2; cfgWe = 1'b0;
  endtask

  task automatic setBuf(logic [NS*NC-1:0] v);
    @(posedge clk); #2; dispBuf = v;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic patterns();
    logic [NS*NC-1:0] sparse;
    for (int i = 0; i < NS*NC; i++) sparse[i] = ((i * 7) % 11) < 3;
    setBuf('1);                  run(100);
    setBuf('0);                  run(100);
    setBuf({65{2'b01}});         run(100);
    setBuf(sparse);              run(100);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    run(3);
    #2;
    // R1: outputs during reset
    check(comLvl == '0, "R1", "comLvl in reset", int'(comLvl), 0);
    check(segLvl == '0, "R1", "segLvl in reset", int'(|segLvl), 0);
    check(&comOe && &segOe, "R1", "oe in reset", int'(&comOe && &segOe), 1);
    check(framePol == 1'b0, "R1", "framePol in reset", framePol, 0);
    rstN = 1'b1;
    run(2); #2;
    check(comLvl == '0 && segLvl == '0, "R1", "blank after reset", int'(|comLvl | |segLvl), 0);

    // R2 R3 R4 R9: half bias, request five commons (active two until wrap)
    writeCfg(6'b00_1101);
    // R6: mid-frame the old two-common scan still holds
    #2;
    if (mIdx <= 1) check(int'(comLvl[2*4 +: 2]) == expCom(4) && mLast == 1, "R6",
                         "com4 before wrap", int'(comLvl[2*4 +: 2]), expCom(4));
    patterns();

    // R3 R4: third bias, three commons
    writeCfg(6'b00_0111);
    patterns();

    // R8: release two high segments and top common, third bias, four commons
    writeCfg(6'b11_1011);
    run(3); #2;
    check(comOe[NC-1] == 1'b0, "R8", "com4 oe", comOe[NC-1], 0);
    check(segOe[NS-1:NS-2] == 2'b00, "R8", "seg top oe", int'(segOe[NS-1:NS-2]), 0);
    patterns();

    // R7: blank while scanning, then back on in half bias five commons
    writeCfg(6'b11_1110);
    run(2); #2;
    check(comLvl == '0 && segLvl == '0, "R7", "blank codes", int'(|comLvl | |segLvl), 0);
    run(120);
    writeCfg(6'b00_1101);
    patterns();

    summary();
  end
endmodule